// File: doc/BRIEF.md
# Command-Driven SPI Master Shifter

This block is a full-duplex SPI master that exchanges one word of 1 to 16 bits per transfer. Software loads a 16-bit shift buffer and an 8-bit rate value through a small write port, then writes a command byte. That byte is both the start trigger and the busy flag. The block checks the command. It asserts an active-low slave select and moves a short word up to the top of the buffer. It then shifts the word out on MOSI, most significant bit first, and collects MISO into the same buffer. Each SCLK half-period is stretched by a programmable delay. When the last bit is done, the block releases slave select and clears the command byte to zero.

Software polls the command byte until it reads zero. It then reads the received word from the buffer, reloads the buffer and issues the next command. A command that is not supported is refused at once and raises a sticky error flag. Only the next accepted command clears that flag.

Top module: `spi_cmd_master`

## Requirements
- R1: Out of reset, the command, buffer, rate and error registers are zero, `ss_n` is 1, and `sclk` and `mosi` are 0.
- R2: `wr_sel` selects the target of a write: 0 is the buffer, 1 is the rate (low 8 bits) and 2 is the command (low 8 bits). A write of any kind is ignored while the command register is non-zero, and the register keeps its value.
- R3: A command with bit 4 or bit 5 clear is refused. One cycle after the write, the error flag is 1 and the command register is 0, while `ss_n` stays 1 and `sclk` does not move.
- R4: An accepted command clears the error flag, drives `ss_n` to 0 and sets `sclk` to the level of command bit 6 (1 = high), all one cycle after the write. Command bit 7 has no effect.
- R5: The word length N is taken from command bits 3:0, and the value 0 means 16.
- R6: For N below 16, the buffer first shifts left 16−N times with zero fill, one shift per cycle. Bits then leave on `mosi` in order from tx bit N−1 down to tx bit 0. Each bit is driven before its first SCLK toggle.
- R7: Every SCLK toggle is preceded by D+2 cycles, where D is the rate value, or 256 when the rate is 0. Each bit takes two toggles.
- R8: At each bit's second toggle, `miso` is written into buffer bit 0. After the transfer the buffer holds the received N-bit word in its low bits, with zeros above.
- R9: One cycle after the last toggle, `ss_n` returns to 1 and the command register becomes 0 in the same cycle. `sclk` is then back at its idle level and does not move while `ss_n` is 1.
- R10: A command write that arrives in the cycle in which the command register is being cleared is ignored, and no new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 buffer, 1 rate, 2 command |
| wr_data | input | 16 | Write data |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| cmd_reg | output | 8 | Command register; 0 means ready |
| buf_reg | output | 16 | Shift buffer (transmit before, receive after) |
| rate_reg | output | 8 | Half-bit delay setting |
| status_err | output | 1 | Unsupported-command flag |

## Verification
Two events can fall in the same cycle: the end of a transfer clears the command register, and software writes a new command. The bench drives the write strobe on exactly the completion edge. It then expects the command register to read zero and `ss_n` to stay high for the following cycles. A second overlap is a register write during the delay phases of an active transfer. The bench writes into the buffer and the command register mid-transfer. It judges the result by the command value it reads on every cycle and by the received word at the end.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALIGN = 3'd1,
        ST_LOAD  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_EDGE  = 3'd4,
        ST_DONE  = 3'd5
    } xfer_state_t;

    localparam logic [1:0] SEL_BUF  = 2'd0;
    localparam logic [1:0] SEL_RATE = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
    parameter int CMD_W = 8,
    parameter int BUF_W = 16,
    parameter int LEN_W = $clog2(BUF_W) + 1
) (
    input  logic [CMD_W-1:0] cmd,
    output logic             valid,
    output logic             idle_high,
    output logic [LEN_W-1:0] nbits,
    output logic [LEN_W-1:0] align
);
    localparam int FIELD_W  = $clog2(BUF_W);
    localparam int BIT_FAST = FIELD_W;
    localparam int BIT_MSTR = FIELD_W + 1;
    localparam int BIT_IDLE = FIELD_W + 2;

    logic [FIELD_W-1:0] len_field;

    always_comb begin
        len_field = cmd[FIELD_W-1:0];
        valid     = cmd[BIT_FAST] & cmd[BIT_MSTR];
        idle_high = cmd[BIT_IDLE];
        nbits     = (len_field == '0) ? LEN_W'(BUF_W) : {1'b0, len_field};
        align     = LEN_W'(BUF_W) - nbits;
    end
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int RATE_W = 8,
    parameter int CNT_W  = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RATE_W-1:0] rate,
    output logic              expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = (rate == '0) ? CNT_W'(1 << RATE_W) : {1'b0, rate};
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        expired = (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int BUF_W  = 16,
    parameter int CMD_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BUF_W-1:0]  wr_data,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n,
    output logic [CMD_W-1:0]  cmd_reg,
    output logic [BUF_W-1:0]  buf_reg,
    output logic [RATE_W-1:0] rate_reg,
    output logic              status_err
);
    localparam int LEN_W = $clog2(BUF_W) + 1;

    typedef struct packed {
        xfer_state_t       st;
        logic [CMD_W-1:0]  cmd;
        logic [RATE_W-1:0] rate;
        logic [BUF_W-1:0]  buff;
        logic              err;
        logic              sclk;
        logic              mosi;
        logic              ss_n;
        logic [LEN_W-1:0]  align;
        logic [LEN_W-1:0]  bits;
        logic              phase;
    } regs_t;

    regs_t q, d;

    logic             dec_valid, dec_idle_high, tmr_load, tmr_expired;
    logic [LEN_W-1:0] dec_nbits, dec_align;

    spi_cmd_decode #(.CMD_W(CMD_W), .BUF_W(BUF_W), .LEN_W(LEN_W)) u_decode (
        .cmd       (q.cmd),
        .valid     (dec_valid),
        .idle_high (dec_idle_high),
        .nbits     (dec_nbits),
        .align     (dec_align)
    );

    spi_half_timer #(.RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .rate    (q.rate),
        .expired (tmr_expired)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;

        if (wr_en && (q.cmd == '0)) begin
            case (wr_sel)
                SEL_BUF:  d.buff = wr_data;
                SEL_RATE: d.rate = wr_data[RATE_W-1:0];
                SEL_CMD:  d.cmd  = wr_data[CMD_W-1:0];
                default:  ;
            endcase
        end

        case (q.st)
            ST_IDLE: begin
                if (q.cmd != '0) begin
                    if (!dec_valid) begin
                        d.err = 1'b1;
                        d.cmd = '0;
                    end else begin
                        d.err   = 1'b0;
                        d.ss_n  = 1'b0;
                        d.sclk  = dec_idle_high;
                        d.bits  = dec_nbits;
                        d.align = dec_align;
                        d.phase = 1'b0;
                        d.st    = (dec_align == '0) ? ST_LOAD : ST_ALIGN;
                    end
                end
            end
            ST_ALIGN: begin
                d.buff  = {q.buff[BUF_W-2:0], 1'b0};
                d.align = q.align - 1'b1;
                if (q.align == LEN_W'(1)) d.st = ST_LOAD;
            end
            ST_LOAD: begin
                tmr_load = 1'b1;
                if (!q.phase) d.mosi = q.buff[BUF_W-1];
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_expired) d.st = ST_EDGE;
            end
            ST_EDGE: begin
                d.sclk = ~q.sclk;
                if (!q.phase) begin
                    d.buff  = {q.buff[BUF_W-2:0], 1'b0};
                    d.bits  = q.bits - 1'b1;
                    d.phase = 1'b1;
                    d.st    = ST_LOAD;
                end else begin
                    d.buff[0] = miso;
                    d.phase   = 1'b0;
                    d.st      = (q.bits == '0) ? ST_DONE : ST_LOAD;
                end
            end
            ST_DONE: begin
                d.ss_n = 1'b1;
                d.cmd  = '0;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ss_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk       = q.sclk;
    assign mosi       = q.mosi;
    assign ss_n       = q.ss_n;
    assign cmd_reg    = q.cmd;
    assign buf_reg    = q.buff;
    assign rate_reg   = q.rate;
    assign status_err = q.err;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd != '0) |=> ((q.cmd == $past(q.cmd)) || (q.cmd == '0))); // R2
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> (q.ss_n && (q.cmd == '0))); // R3
    AST_READY_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == '0) |-> q.ss_n); // R9
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ss_n && $past(q.ss_n)) |-> $stable(q.sclk)); // R9
endmodule

// File: tb/spi_cmd_master_tb.sv
module spi_cmd_master_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, ss_n, status_err;
    logic [7:0]  cmd_reg, rate_reg;
    logic [15:0] buf_reg;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_cmd_master u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .miso(miso), .sclk(sclk), .mosi(mosi),
        .ss_n(ss_n), .cmd_reg(cmd_reg), .buf_reg(buf_reg),
        .rate_reg(rate_reg), .status_err(status_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic step(input logic es, input logic ek, input bit mv,
                        input logic em, input logic [7:0] ec, input string tag);
        @(posedge clk); @(negedge clk);
        chk({tag, " ss_n"}, ss_n, es);
        chk({tag, " sclk"}, sclk, ek);
        chk({tag, " cmd"}, cmd_reg, ec);
        if (mv) chk({tag, " mosi"}, mosi, em);
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] r, input logic [15:0] tx,
                        input logic [15:0] rx, input bit mid_wr, input bit collide);
        int n = (c[3:0] == 4'd0) ? 16 : int'(c[3:0]);
        int dl = (r == 8'd0) ? 256 : int'(r);
        int a = 16 - n;
        logic ks = c[6];
        logic km = 1'b0;
        bit mv = 0;
        logic [15:0] mask = (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
        wreg(2'd0, tx);
        chk("R2 idle buffer write", buf_reg, tx);
        wreg(2'd1, {8'h00, r});
        wreg(2'd2, {8'h00, c});
        step(1'b0, ks, 0, 1'b0, c, "R4");
        chk("R4 error cleared", status_err, 1'b0);
        for (int k = 0; k < a; k++) step(1'b0, ks, 0, 1'b0, c, "R6 align");
        for (int i = 0; i < n; i++) begin
            miso = rx[n-1-i];
            km = tx[n-1-i]; mv = 1;
            step(1'b0, ks, mv, km, c, "R6 bit");
            for (int k = 0; k < dl; k++) step(1'b0, ks, mv, km, c, "R7 wait");
            ks = ~ks;
            step(1'b0, ks, mv, km, c, "R7 first toggle");
            if (mid_wr && i == 0) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'hFFFF;
            end
            step(1'b0, ks, mv, km, c, "R7 reload");
            if (mid_wr && i == 0) begin
                wr_sel = 2'd2; wr_data = 16'h00F3;
            end
            for (int k = 0; k < dl; k++) begin
                step(1'b0, ks, mv, km, c, "R2 busy write");
                wr_en = 1'b0; wr_sel = 2'd3;
            end
            ks = ~ks;
            step(1'b0, ks, mv, km, c, "R8 second toggle");
        end
        if (collide) begin
            wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h00F4;
        end
        step(1'b1, ks, mv, km, 8'h00, "R9 done");
        wr_en = 1'b0; wr_sel = 2'd3;
        chk("R8 received word", buf_reg, rx & mask);
        chk("R9 sclk idle level", sclk, c[6]);
        chk("R5 R4 no error", status_err, 1'b0);
        if (collide)
            for (int k = 0; k < 4; k++) step(1'b1, ks, mv, km, 8'h00, "R10 collide ignored");
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ss_n", ss_n, 1'b1);
        chk("R1 sclk", sclk, 1'b0);
        chk("R1 mosi", mosi, 1'b0);
        chk("R1 cmd", cmd_reg, 8'h00);
        chk("R1 buf", buf_reg, 16'h0000);
        chk("R1 err", status_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rate", rate_reg, 8'h00);

        wreg(2'd2, 16'h001C);
        chk("R3 latched", cmd_reg, 8'h1C);
        step(1'b1, 1'b0, 0, 1'b0, 8'h00, "R3 reject bit5");
        chk("R3 error set", status_err, 1'b1);
        wreg(2'd2, 16'h0025);
        step(1'b1, 1'b0, 0, 1'b0, 8'h00, "R3 reject bit4");
        chk("R3 error still set", status_err, 1'b1);

        xfer(8'hF0, 8'd3, 16'h0D35, 16'hA5C3, 0, 0);
        xfer(8'hBC, 8'd1, 16'h0ABC, 16'h05A3, 0, 0);
        xfer(8'h31, 8'd0, 16'h0001, 16'h0001, 0, 0);
        xfer(8'h75, 8'd2, 16'h0013, 16'h000A, 1, 1);
        chk("R2 rate readback", rate_reg, 8'd2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule